// File: doc/BRIEF.md
# Interprocessor and Interval-Timer Interrupt Controller

This block holds one 64-bit control word shared by four processors and one 25-bit interval-ignore counter per processor. From these it produces an inter-processor interrupt line and an interval-timer interrupt line for every processor. Software reaches the state through a simple register port. Every access is a full 64-bit word and carries the index of the processor that issues it.

The control word mixes several field behaviours:
- pending bits that software clears by writing 1;
- a pair of 4-bit capture fields with set-only and set-only-when-empty rules, plus one acknowledge bit that empties both fields;
- request bits that raise the pending interrupt of another processor;
- a plain read-write nibble.

A periodic tick input drives all four counters. A counter that has run past zero keeps a sticky overflow flag. From then on, every tick marks a timer interrupt as pending for that processor until software reloads the counter.

Offsets that belong to memory, power or monitor functions outside this block read as zero and ignore writes. Any other offset reads all ones and raises an error pulse.

Top module: `ipt_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0008_0000_0000 (bit 35 set, OR'ed with the requester index), every counter reads 0, and `ipi_irq`, `tmr_irq`, `rd_data` and `err` are all zero.
- R2: A write to the control word (offset 0x000) clears each timer-pending bit 4+i and each interprocessor-pending bit 8+i that is written as 1. Bit 28 is also write-1-to-clear, and it reads 0 because nothing in this block sets it.
- R3: A write with bit 20 set clears bits 23:16. A write with bit 20 clear ORs the written bits 23:20 into the stored bits 23:20.
- R4: When bit 20 is written as 0 and the stored bits 19:16 are all zero, the written bits 19:16 are loaded. When the stored bits 19:16 are not all zero, they keep their value.
- R5: Writing 1 to bit 12+i sets pending bit 8+i, and this set is applied after the clears of R2. `ipi_irq[i]` equals stored bit 8+i from the clock edge of the write onward. Bits 15:12 read as 0.
- R6: Bits 43:40 hold the last written value. All other control-word bits not named in R2 to R5 ignore writes, and bit 35 stays 1.
- R7: A read returns its data on `rd_data` one clock after the request. For the control word, the requester index `req_cpu` is OR'ed into bits 1:0. `rd_data` holds its value until the next read.
- R8: Processor i's counter sits at offset 0x100 + 0x40*i. A write loads bits 23:0 from the write data and clears the overflow flag in bit 24. A read returns the 25 bits zero-extended.
- R9: On each clock where `tick_in` is 1 and was 0 on the previous clock, every counter that is not being written decrements bits 23:0, wrapping around. A counter that was at 0 sets bit 24, and bit 24 then stays set until that counter is written.
- R10: On each rising tick after which a counter's bit 24 is set, control bit 4+i and `tmr_irq[i]` become 1. `tmr_irq[i]` equals control bit 4+i. A register write never raises `tmr_irq`, and clearing bit 4+i lowers it at the clock edge of the write.
- R11: A tick input that stays high, stays low or falls changes no counter and no pending bit.
- R12: Offsets 0x040, 0x080, 0x0C0 and 0x200 to 0x3C0 (in steps of 0x40) read 0, ignore writes and raise no error. Any other offset returns all ones on a read and pulses `err` for one clock on either a read or a write, one clock after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_cpu | input | 2 | Index of the requesting processor |
| req_wdata | input | 64 | Write data |
| tick_in | input | 1 | Periodic interval tick, acted on at its rising edge |
| rd_data | output | 64 | Read data, valid one clock after a read request |
| err | output | 1 | One-clock pulse after an access to an unmapped offset |
| ipi_irq | output | 4 | Inter-processor interrupt per processor |
| tmr_irq | output | 4 | Interval-timer interrupt per processor |

## Verification
Each result becomes visible at a fixed point after its stimulus:
- Writes and rising ticks update the stored state and both interrupt vectors at the clock edge that samples them.
- Read data and the error pulse appear one register stage after the request.
- The registered copy of the tick adds no delay to the effect of a rise, but a held level must not act again on later edges.

The bench drives every input on the falling edge and samples one falling edge after the rising edge that acts on it. The tick checks therefore look at the interrupt lines and counters exactly one edge after each rise, and again several edges into a held-high level. A reference model of the control word and counters, updated by the bench at the same points, supplies every expected value during the sweep of mixed writes and ticks.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    localparam int unsigned WORD_W    = 64;
    localparam int unsigned TPEND_LSB = 4;   // timer pending, one bit per processor
    localparam int unsigned IPEND_LSB = 8;   // interprocessor pending
    localparam int unsigned IPREQ_LSB = 12;  // interprocessor request, reads zero
    localparam int unsigned CAPLO_LSB = 16;  // set only while empty
    localparam int unsigned CAPHI_LSB = 20;  // set only
    localparam int unsigned ACK_BIT   = 20;  // write 1 empties both capture fields
    localparam int unsigned ERRF_BIT  = 28;  // clear-only flag, never set here
    localparam int unsigned REV_BIT   = 35;  // constant identification bit
    localparam int unsigned USER_LSB  = 40;  // plain read-write nibble
    localparam int unsigned REG_SHIFT = 6;   // registers on 0x40 boundaries

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_RSVD = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;
endpackage

// File: rtl/ipt_decode.sv
module ipt_decode
    import ipt_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NCPU   = 4
) (
    input  logic [ADDR_W-1:0]                     addr,
    output sel_e                                  sel,
    output logic [((NCPU > 1) ? $clog2(NCPU) : 1)-1:0] idx
);
    localparam int unsigned IDX_W     = (NCPU > 1) ? $clog2(NCPU) : 1;
    localparam int unsigned SLOT_W    = ADDR_W - REG_SHIFT;
    localparam int unsigned CNT_SLOT0 = 4;
    localparam int unsigned RSV_HI_LO = 8;
    localparam int unsigned RSV_HI_HI = 15;

    logic [SLOT_W-1:0] slot;
    logic              aligned;

    always_comb begin
        slot    = addr[ADDR_W-1:REG_SHIFT];
        aligned = (addr[REG_SHIFT-1:0] == '0);
        idx     = IDX_W'(slot - SLOT_W'(CNT_SLOT0));
        sel     = SEL_NONE;
        if (aligned) begin
            if (slot == '0)
                sel = SEL_CTRL;
            else if (slot < SLOT_W'(CNT_SLOT0))
                sel = SEL_RSVD;
            else if (slot < SLOT_W'(CNT_SLOT0 + NCPU))
                sel = SEL_CNT;
            else if (slot >= SLOT_W'(RSV_HI_LO) && slot <= SLOT_W'(RSV_HI_HI))
                sel = SEL_RSVD;
        end
    end
endmodule

// File: rtl/ipt_ivl_counter.sv
module ipt_ivl_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    output logic [CNT_W:0]   cnt_o,
    output logic             fire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             ovf;
        logic [CNT_W-1:0] val;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (ld) begin
            st_d.val = ld_val;
            st_d.ovf = 1'b0;
        end else if (tick) begin
            st_d.val = st_q.val - ONE;
            st_d.ovf = st_q.ovf | (st_q.val == '0);
            fire_o   = st_d.ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q;

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_o == {1'b0, $past(ld_val)}));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o[CNT_W] && !ld) |=> cnt_o[CNT_W]);

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !tick) |=> $stable(cnt_o));
endmodule

// File: rtl/ipt_ctrl_word.sv
module ipt_ctrl_word
    import ipt_pkg::*;
#(
    parameter int unsigned NCPU = 4   // field layout allows at most four
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wd,
    input  logic [NCPU-1:0]   fire,
    output logic [WORD_W-1:0] word_o,
    output logic [NCPU-1:0]   ipi_o,
    output logic [NCPU-1:0]   tmr_o
);
    typedef struct packed {
        logic [3:0]      user;
        logic [3:0]      cap_hi;
        logic [3:0]      cap_lo;
        logic [NCPU-1:0] ipend;
        logic [NCPU-1:0] tpend;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr) begin
            c_d.tpend = c_q.tpend & ~wd[TPEND_LSB +: NCPU];
            c_d.ipend = c_q.ipend & ~wd[IPEND_LSB +: NCPU];
            if (wd[ACK_BIT]) begin
                c_d.cap_hi = '0;
                c_d.cap_lo = '0;
            end else begin
                c_d.cap_hi = c_q.cap_hi | wd[CAPHI_LSB +: 4];
                if (c_q.cap_lo == '0)
                    c_d.cap_lo = wd[CAPLO_LSB +: 4];
            end
            c_d.ipend = c_d.ipend | wd[IPREQ_LSB +: NCPU];
            c_d.user  = wd[USER_LSB +: 4];
        end
        c_d.tpend = c_d.tpend | fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        word_o                       = '0;
        word_o[TPEND_LSB +: NCPU]    = c_q.tpend;
        word_o[IPEND_LSB +: NCPU]    = c_q.ipend;
        word_o[CAPLO_LSB +: 4]       = c_q.cap_lo;
        word_o[CAPHI_LSB +: 4]       = c_q.cap_hi;
        word_o[REV_BIT]              = 1'b1;
        word_o[USER_LSB +: 4]        = c_q.user;
    end

    assign ipi_o = c_q.ipend;
    assign tmr_o = c_q.tpend;

    assert_no_write_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire == '0) |=> ((tmr_o & ~$past(tmr_o)) == '0));

    assert_ack_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wd[ACK_BIT]) |=> (word_o[CAPLO_LSB +: 8] == 8'h00));

    assert_caplo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wd[ACK_BIT] && word_o[CAPLO_LSB +: 4] != 4'h0)
        |=> (word_o[CAPLO_LSB +: 4] == $past(word_o[CAPLO_LSB +: 4])));

    assert_ipi_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((ipi_o & $past(wd[IPREQ_LSB +: NCPU])) == $past(wd[IPREQ_LSB +: NCPU])));
endmodule

// File: rtl/ipt_irq_ctrl.sv
module ipt_irq_ctrl
    import ipt_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NCPU   = 4,
    parameter int unsigned CNT_W  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_cpu,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic                  tick_in,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  err,
    output logic [NCPU-1:0]       ipi_irq,
    output logic [NCPU-1:0]       tmr_irq
);
    localparam int unsigned IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] rd;
        logic              err;
        logic              tick_prev;
    } top_t;

    top_t t_d, t_q;

    sel_e              sel;
    logic [IDX_W-1:0]  idx;
    logic              tick_rise;
    logic              wr_ctrl;
    logic [NCPU-1:0]   ld;
    logic [NCPU-1:0]   fire;
    logic [CNT_W:0]    cnt_arr [NCPU];
    logic [WORD_W-1:0] word;

    ipt_decode #(.ADDR_W(ADDR_W), .NCPU(NCPU)) u_dec (
        .addr (req_addr),
        .sel  (sel),
        .idx  (idx)
    );

    assign tick_rise = tick_in & ~t_q.tick_prev;
    assign wr_ctrl   = req_valid & req_write & (sel == SEL_CTRL);

    for (genvar g = 0; g < NCPU; g++) begin : g_cnt
        assign ld[g] = req_valid & req_write & (sel == SEL_CNT) & (idx == IDX_W'(g));
        ipt_ivl_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld[g]),
            .ld_val (req_wdata[CNT_W-1:0]),
            .tick   (tick_rise),
            .cnt_o  (cnt_arr[g]),
            .fire_o (fire[g])
        );
    end

    ipt_ctrl_word #(.NCPU(NCPU)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ctrl),
        .wd     (req_wdata),
        .fire   (fire),
        .word_o (word),
        .ipi_o  (ipi_irq),
        .tmr_o  (tmr_irq)
    );

    always_comb begin
        t_d           = t_q;
        t_d.tick_prev = tick_in;
        t_d.err       = 1'b0;
        if (req_valid) begin
            t_d.err = (sel == SEL_NONE);
            if (!req_write) begin
                unique case (sel)
                    SEL_CTRL: t_d.rd = word | WORD_W'(req_cpu);
                    SEL_CNT:  t_d.rd = WORD_W'(cnt_arr[idx]);
                    SEL_RSVD: t_d.rd = '0;
                    default:  t_d.rd = '1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rd_data = t_q.rd;
    assign err     = t_q.err;

    assert_err_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid));

    assert_held_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && $past(tick_in) && !req_valid) |=> $stable(tmr_irq));
endmodule

// File: tb/tb_ipt_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ipt_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_cpu = '0;
    logic [63:0] req_wdata = '0;
    logic        tick_in = 1'b0;
    logic [63:0] rd_data;
    logic        err;
    logic [3:0]  ipi_irq;
    logic [3:0]  tmr_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_ctrl;
    logic [24:0] m_cnt [4];

    always #2 clk = ~clk;

    ipt_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_cpu(req_cpu), .req_wdata(req_wdata),
        .tick_in(tick_in), .rd_data(rd_data), .err(err),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] apply_wr(input logic [63:0] o, input logic [63:0] w);
        logic [63:0] n;
        n = o & ~(w & 64'h0000_0000_1000_0FF0);
        if (w[20]) n[23:16] = 8'h00;
        else begin
            n[23:20] = n[23:20] | w[23:20];
            if (n[19:16] == 4'h0) n[19:16] = w[19:16];
        end
        n[11:8]  = n[11:8] | w[15:12];
        n[43:40] = w[43:40];
        return n;
    endfunction

    function automatic logic [11:0] cnt_addr(input int i);
        return 12'h100 + 12'(i * 64);
    endfunction

    task automatic bus_wr(input logic [11:0] a, input logic [63:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_cpu = 2'd0;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        e = err;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [1:0] c,
                          output logic [63:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_cpu = c; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data; e = err;
    endtask

    task automatic wr_ctrl(input logic [63:0] w);
        logic e;
        bus_wr(12'h000, w, e);
        m_ctrl = apply_wr(m_ctrl, w);
        chk("R5 ipi_irq after write", 64'(ipi_irq), 64'(m_ctrl[11:8]));
        chk("R10 tmr_irq after write", 64'(tmr_irq), 64'(m_ctrl[7:4]));
    endtask

    task automatic rd_ctrl(input logic [1:0] c, input string tag, output logic [63:0] d);
        logic e;
        bus_rd(12'h000, c, d, e);
        chk(tag, d, m_ctrl | 64'(c));
    endtask

    task automatic wr_cnt(input int i, input logic [63:0] v);
        logic e;
        bus_wr(cnt_addr(i), v, e);
        m_cnt[i] = {1'b0, v[23:0]};
    endtask

    task automatic rd_cnts(input string tag);
        logic [63:0] d;
        logic e;
        for (int i = 0; i < 4; i++) begin
            bus_rd(cnt_addr(i), 2'(i), d, e);
            chk(tag, d, 64'(m_cnt[i]));
        end
    endtask

    task automatic model_tick;
        for (int i = 0; i < 4; i++) begin
            if (m_cnt[i][23:0] == 24'h0) m_cnt[i][24] = 1'b1;
            m_cnt[i][23:0] = m_cnt[i][23:0] - 24'h1;
            if (m_cnt[i][24]) m_ctrl[4+i] = 1'b1;
        end
    endtask

    task automatic do_tick;
        @(negedge clk); tick_in = 1'b1;
        @(negedge clk); tick_in = 1'b0;
        model_tick();
        chk("R10 tmr_irq after tick", 64'(tmr_irq), 64'(m_ctrl[7:4]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic e;
        logic [63:0] s;
        logic [63:0] w;

        m_ctrl = 64'h0000_0008_0000_0000;
        for (int i = 0; i < 4; i++) m_cnt[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ipi_irq reset", 64'(ipi_irq), 64'h0);
        chk("R1 tmr_irq reset", 64'(tmr_irq), 64'h0);
        chk("R1 rd_data reset", rd_data, 64'h0);
        chk("R1 err reset", 64'(err), 64'h0);
        rd_ctrl(2'd2, "R1 R7 reset word with cpu 2", d);
        chk("R1 reset word value", d, 64'h0000_0008_0000_0002);
        rd_cnts("R1 counters reset");

        // R7 requester index and hold
        rd_ctrl(2'd3, "R7 cpu 3 index", d);
        @(negedge clk);
        chk("R7 rd_data holds", rd_data, m_ctrl | 64'd3);

        // R4 set-if-empty, R3 set-only and acknowledge
        wr_ctrl(64'h0000_0000_0003_0000);
        rd_ctrl(2'd0, "R4 load when empty", d);
        chk("R4 low capture", 64'(d[19:16]), 64'h3);
        wr_ctrl(64'h0000_0000_0005_0000);
        rd_ctrl(2'd0, "R4 hold when nonempty", d);
        chk("R4 low capture kept", 64'(d[19:16]), 64'h3);
        wr_ctrl(64'h0000_0000_00A0_0000);
        wr_ctrl(64'h0000_0000_0040_0000);
        rd_ctrl(2'd1, "R3 set only", d);
        chk("R3 high capture OR", 64'(d[23:20]), 64'hE);
        wr_ctrl(64'h0000_0000_00FF_0000);
        rd_ctrl(2'd1, "R3 ack", d);
        chk("R3 ack empties 23:16", 64'(d[23:16]), 64'h0);
        wr_ctrl(64'h0000_0000_0005_0000);
        rd_ctrl(2'd0, "R4 reload after ack", d);
        chk("R4 low capture after ack", 64'(d[19:16]), 64'h5);

        // R5 request and R2 clear
        wr_ctrl(64'h0000_0000_0000_5000);
        chk("R5 ipi raised", 64'(ipi_irq), 64'h5);
        wr_ctrl(64'h0000_0000_1000_0100);
        chk("R2 ipi bit 8 cleared", 64'(ipi_irq), 64'h4);
        rd_ctrl(2'd0, "R2 R5 bits 15:12 and 28 read zero", d);
        chk("R5 request field zero", 64'(d[15:12]), 64'h0);

        // R6 user nibble and ignored bits
        wr_ctrl(64'h0000_0A00_0000_0000);
        rd_ctrl(2'd0, "R6 user nibble", d);
        chk("R6 user value", 64'(d[43:40]), 64'hA);
        wr_ctrl(64'hFFFF_F0F7_E000_000F);
        rd_ctrl(2'd2, "R6 ignored bits", d);
        chk("R6 rev bit stays", 64'(d[35]), 64'h1);

        // R8 counter load
        wr_cnt(1, 64'h0000_0000_01AB_CDEF);
        rd_cnts("R8 load clears bit 24");

        // R9 R10 ticks
        wr_cnt(0, 64'd2); wr_cnt(1, 64'd0); wr_cnt(2, 64'd5); wr_cnt(3, 64'd1);
        for (int k = 0; k < 3; k++) begin
            do_tick();
            rd_cnts("R9 counters after tick");
        end
        chk("R10 tmr after three ticks", 64'(tmr_irq), 64'hB);

        // R10 clear drops, write never raises, sticky re-fire
        wr_ctrl(64'h0000_0000_0000_0020);
        chk("R10 clear drops tmr 1", 64'(tmr_irq[1]), 64'h0);
        wr_ctrl(64'h0000_0000_0000_0000);
        chk("R10 write does not raise", 64'(tmr_irq[1]), 64'h0);
        do_tick();
        chk("R9 R10 sticky re-fire", 64'(tmr_irq[1]), 64'h1);

        // R8 reload clears overflow so no fire
        wr_cnt(1, 64'd10);
        wr_ctrl(64'h0000_0000_0000_0020);
        do_tick();
        chk("R8 reload stops fire", 64'(tmr_irq[1]), 64'h0);
        rd_cnts("R8 reload counters");

        // R11 held high and falling edges
        wr_ctrl(64'h0000_0000_0000_00F0);
        @(negedge clk); tick_in = 1'b1;
        repeat (6) @(negedge clk);
        model_tick();
        chk("R11 single act while held", 64'(tmr_irq), 64'(m_ctrl[7:4]));
        wr_ctrl(64'h0000_0000_0000_00F0);
        repeat (3) @(negedge clk);
        chk("R11 held high no re-fire", 64'(tmr_irq), 64'h0);
        tick_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 fall no effect", 64'(tmr_irq), 64'h0);
        rd_cnts("R11 counters after hold");

        // R12 reserved and unmapped
        bus_rd(12'h040, 2'd0, d, e);
        chk("R12 reserved reads zero", d, 64'h0);
        chk("R12 reserved no err", 64'(e), 64'h0);
        bus_wr(12'h280, 64'hDEAD_BEEF_0000_FFFF, e);
        chk("R12 reserved write no err", 64'(e), 64'h0);
        bus_rd(12'h280, 2'd0, d, e);
        chk("R12 reserved write ignored", d, 64'h0);
        bus_rd(12'h008, 2'd0, d, e);
        chk("R12 unaligned all ones", d, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R12 unaligned err", 64'(e), 64'h1);
        @(negedge clk);
        chk("R12 err one cycle", 64'(err), 64'h0);
        bus_wr(12'h400, 64'hFFFF_FFFF_FFFF_FFFF, e);
        chk("R12 unmapped write err", 64'(e), 64'h1);
        rd_ctrl(2'd1, "R12 unmapped write ignored", d);
        rd_cnts("R12 counters untouched");

        // Sweep of mixed writes and ticks against the model
        wr_cnt(0, 64'd3); wr_cnt(1, 64'd0); wr_cnt(2, 64'd7); wr_cnt(3, 64'd1);
        s = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 300; k++) begin
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            w = s & 64'h0000_FFFF_F0FF_FFFF;
            if (s[63:62] != 2'b00) w[20] = 1'b0;
            wr_ctrl(w);
            rd_ctrl(2'(k), "R2/R3/R4/R5/R6 sweep word", d);
            if (k % 4 == 3) do_tick();
            if (k % 50 == 49) rd_cnts("R9 sweep counters");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule